// File: doc/BRIEF.md
# Pad Pull Resistor Latch Sequencer

This block holds the pull resistor setting of every pad in a bank of 54 pins and drives the pull-up and pull-down enables of each pad. Software never writes a pin's pull setting directly. It first places a 2-bit pull code in a shared control register. It then sets bits in a pair of pin strobe registers, one bit per pin. Every pin whose strobe bit has been held long enough copies the shared code into its own private setting. Software then clears the strobe bits. The private settings cannot be read back. Only the control code and the strobe masks can be read.

The block enforces the wait times in clock cycles of its own clock. A single timer restarts on every write to the control register or to either strobe register. A pin takes the code only once that timer has run for `HOLD_CYCLES` cycles while the pin's strobe bit is still set. If the strobe is removed earlier, or the code is rewritten in the meantime, the pins keep their previous setting.

The register bus takes one request per cycle with a valid/ready handshake. `bus_ready` is low only while reset is asserted and in the first cycle after it is released. A request is accepted in any cycle where `bus_valid` and `bus_ready` are both high. Read data has no back-pressure: it comes back as a single-cycle `rd_valid` pulse one cycle after the read is accepted.

Top module: `pull_seq`

## Requirements
- R1: After reset every pin drives pull-up and pull-down low (default setting "off"). The control register and both strobe registers read 0, and `bus_ready` is high from the second cycle after reset is released.
- R2: The control register is at byte address 0x94. Bits [1:0] of a write are stored and read back. All other read bits are 0.
- R3: The strobe registers are at 0x98 (bit n is pin n, for pins 0 to 31) and 0x9C (bit n is pin 32+n, for pins 32 to 53). They read back what was written. Bits 22 to 31 of 0x9C read 0.
- R4: Pull code 0 clears both enables, code 1 sets only pull-down, and code 2 sets only pull-up. No pin ever has both enables high.
- R5: Pull code 3 is reserved. While it is the stored code, no pin's setting changes, even with its strobe bit held.
- R6: A pin copies the code at the clock edge that comes HOLD_CYCLES+1 edges (151 by default) after the most recent write to the control or strobe registers, provided its strobe bit is still set at that edge. A strobe that is cleared sooner leaves the setting unchanged.
- R7: A pin whose strobe bit is clear never changes its setting.
- R8: A write to the control register while strobe bits are set restarts the hold count, so the total time the strobe has been set does not count.
- R9: A read is answered with `rd_valid` high exactly one cycle after it is accepted. Reads of any other address return 0, and writes to other addresses change nothing that can be observed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present |
| bus_ready | output | 1 | Request can be accepted this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, single-cycle pulse |
| rd_data | output | 32 | Read data |
| pull_up_en | output | 54 | Per-pin pull-up enable to the pads |
| pull_dn_en | output | 54 | Per-pin pull-down enable to the pads |

## Verification
The assertions assume that `bus_valid`, `bus_write` and `bus_addr` are always known, and that a request is held for exactly one accepted cycle. They also assume that the strobe and code registers change only through accepted bus writes, so that every change of a pin's setting can be traced to a timer that has matured. The stimulus drives each request for one cycle, one time unit after a clock edge, and never during reset. It spaces the clearing writes at measured edge counts on both sides of the hold limit, so the 149/150 boundary and the code-3 and restart cases all occur within the assumed protocol.

// File: rtl/pull_seq_pkg.sv
package pull_seq_pkg;

  typedef enum logic [1:0] {
    PULL_OFF  = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_KEEP = 2'd3
  } pull_code_e;

  function automatic logic code_up(input pull_code_e c);
    return c == PULL_UP;
  endfunction

  function automatic logic code_dn(input pull_code_e c);
    return c == PULL_DOWN;
  endfunction

endpackage

// File: rtl/pull_seq_regs.sv
module pull_seq_regs
  import pull_seq_pkg::*;
#(
  parameter int NUM_PINS  = 54,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CTRL_ADDR = 'h94,
  parameter int STRB_ADDR = 'h98
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output pull_code_e          code,
  output logic [NUM_PINS-1:0] strobe,
  output logic                restart
);

  localparam int NUM_BANKS = (NUM_PINS + DATA_W - 1) / DATA_W;
  localparam int BYTES     = DATA_W / 8;
  localparam int PAD_W     = NUM_BANKS * DATA_W - NUM_PINS;

  logic                          ready_q;
  logic                          accept;
  logic                          ctrl_hit;
  logic [NUM_BANKS-1:0]          bank_hit;
  pull_code_e                    code_q;
  logic [NUM_PINS-1:0]           strobe_q;
  logic [NUM_BANKS*DATA_W-1:0]   strobe_pad;
  logic [DATA_W-1:0]             or_chain [NUM_BANKS+1];
  logic [DATA_W-1:0]             rd_next;
  logic                          rd_valid_q;
  logic [DATA_W-1:0]             rd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign bus_ready = ready_q;
  assign accept    = bus_valid && ready_q;
  assign ctrl_hit  = bus_addr == ADDR_W'(CTRL_ADDR);

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign bank_hit[gb] = bus_addr == ADDR_W'(STRB_ADDR + gb * BYTES);
      assign or_chain[gb+1] = or_chain[gb] |
                              (bank_hit[gb] ? strobe_pad[gb*DATA_W +: DATA_W] : '0);
    end
    if (PAD_W > 0) begin : g_pad
      assign strobe_pad = {{PAD_W{1'b0}}, strobe_q};
    end else begin : g_nopad
      assign strobe_pad = strobe_q;
    end
  endgenerate

  assign or_chain[0] = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= PULL_OFF;
    else if (accept && bus_write && ctrl_hit) code_q <= pull_code_e'(bus_wdata[1:0]);
  end

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PINS; gp++) begin : g_pin
      localparam int BANK = gp / DATA_W;
      localparam int BIT  = gp % DATA_W;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_q[gp] <= 1'b0;
        else if (accept && bus_write && bank_hit[BANK]) strobe_q[gp] <= bus_wdata[BIT];
      end
    end
  endgenerate

  always_comb begin
    rd_next = or_chain[NUM_BANKS];
    if (ctrl_hit) rd_next = rd_next | DATA_W'(code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= accept && !bus_write;
      if (accept && !bus_write) rd_data_q <= rd_next;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign code     = code_q;
  assign strobe   = strobe_q;
  assign restart  = accept && bus_write && (ctrl_hit || (|bank_hit));

  // R9: every accepted read is answered on the next cycle
  p_read_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write) |=> rd_valid);
  // R9: no answer without a request
  p_read_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_valid && bus_ready && !bus_write));

endmodule

// File: rtl/pull_seq_timer.sv
module pull_seq_timer #(
  parameter int HOLD_CYCLES = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic mature
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               cnt_q <= '0;
    else if (restart)                         cnt_q <= '0;
    else if (cnt_q != CNT_W'(HOLD_CYCLES))    cnt_q <= cnt_q + 1'b1;
  end

  assign mature = cnt_q == CNT_W'(HOLD_CYCLES);

  // R8: a register write always clears a matured window
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !mature);

endmodule

// File: rtl/pull_seq_bank.sv
module pull_seq_bank
  import pull_seq_pkg::*;
#(
  parameter int         NUM_PINS   = 54,
  parameter pull_code_e RESET_CODE = PULL_OFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pull_code_e          code,
  input  logic [NUM_PINS-1:0] strobe,
  input  logic                mature,
  output logic [NUM_PINS-1:0] up_en,
  output logic [NUM_PINS-1:0] dn_en
);

  logic load_ok;
  assign load_ok = mature && (code != PULL_KEEP);

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PINS; gp++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          up_en[gp] <= code_up(RESET_CODE);
          dn_en[gp] <= code_dn(RESET_CODE);
        end else if (load_ok && strobe[gp]) begin
          up_en[gp] <= code_up(code);
          dn_en[gp] <= code_dn(code);
        end
      end

      // R7: an unstrobed pin holds its setting
      p_unstrobed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe[gp]) |-> $stable({up_en[gp], dn_en[gp]}));
    end
  endgenerate

  // R4: the two enables of a pin are never on together
  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en & dn_en) == '0);
  // R5: reserved code never moves a setting
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code) == PULL_KEEP) |-> $stable({up_en, dn_en}));
  // R6: settings change only after a matured hold window
  p_matured_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({up_en, dn_en}) |-> $past(mature));

endmodule

// File: rtl/pull_seq.sv
module pull_seq
  import pull_seq_pkg::*;
#(
  parameter int         NUM_PINS    = 54,
  parameter int         HOLD_CYCLES = 150,
  parameter int         ADDR_W      = 8,
  parameter int         DATA_W      = 32,
  parameter int         CTRL_ADDR   = 'h94,
  parameter int         STRB_ADDR   = 'h98,
  parameter pull_code_e RESET_CODE  = PULL_OFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_valid,
  output logic                bus_ready,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_PINS-1:0] pull_up_en,
  output logic [NUM_PINS-1:0] pull_dn_en
);

  pull_code_e          code;
  logic [NUM_PINS-1:0] strobe;
  logic                restart;
  logic                mature;

  pull_seq_regs #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR),
    .STRB_ADDR(STRB_ADDR)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_ready(bus_ready),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .code     (code),
    .strobe   (strobe),
    .restart  (restart)
  );

  pull_seq_timer #(
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .mature (mature)
  );

  pull_seq_bank #(
    .NUM_PINS  (NUM_PINS),
    .RESET_CODE(RESET_CODE)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (code),
    .strobe(strobe),
    .mature(mature),
    .up_en (pull_up_en),
    .dn_en (pull_dn_en)
  );

endmodule

// File: tb/pull_seq_bench.sv
`timescale 1ns/1ps
module pull_seq_bench;

  localparam int HOLD = 150;
  localparam int NP   = 54;

  typedef struct packed {
    logic [1:0]  code;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [31:0] gap;
    logic [31:0] tag;
  } vec_t;

  // R4 normal loads, R6 boundary 149 vs 150, R5 reserved code, R7 unstrobed pins
  localparam vec_t VECS [8] = '{
    '{2'd1, 32'h0000_000F, 32'h0000_0000, 32'd150, 32'd4},
    '{2'd2, 32'h8000_0000, 32'h0020_0001, 32'd200, 32'd4},
    '{2'd0, 32'h0000_0001, 32'h0000_0000, 32'd150, 32'd4},
    '{2'd2, 32'h0000_0002, 32'h0000_0000, 32'd149, 32'd6},
    '{2'd3, 32'h0000_0004, 32'h0000_0001, 32'd160, 32'd5},
    '{2'd1, 32'h0000_0000, 32'h0020_0000, 32'd150, 32'd7},
    '{2'd2, 32'hFFFF_FFFF, 32'h003F_FFFF, 32'd10,  32'd6},
    '{2'd2, 32'h0000_0F00, 32'h0000_0000, 32'd151, 32'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_ready;
  logic          bus_write = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NP-1:0] pull_up_en;
  logic [NP-1:0] pull_dn_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [NP-1:0] exp_up = '0;
  logic [NP-1:0] exp_dn = '0;
  logic [31:0]   rv;

  always #5 clk = ~clk;

  pull_seq #(.HOLD_CYCLES(HOLD)) u_pull_seq (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic v;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 pull_up_en", 64'(pull_up_en), 64'(0));
    check("R1 pull_dn_en", 64'(pull_dn_en), 64'(0));
    check("R1 bus_ready",  64'(bus_ready), 64'(1));
    rd(8'h94, rv, v);
    check("R1 ctrl after reset", 64'(rv), 64'(0));

    // R2 control readback keeps two bits
    wr(8'h94, 32'hFFFF_FFFE);
    rd(8'h94, rv, v);
    check("R2 ctrl readback", 64'(rv), 64'(2));

    // R3 strobe readback, unused upper bits of second word read 0
    wr(8'h9C, 32'hFFFF_FFFF);
    rd(8'h9C, rv, v);
    check("R3 strobe high word", 64'(rv), 64'h003F_FFFF);
    wr(8'h98, 32'hA5A5_0001);
    rd(8'h98, rv, v);
    check("R3 strobe low word", 64'(rv), 64'hA5A5_0001);
    wr(8'h98, 32'h0);
    wr(8'h9C, 32'h0);
    check("R3 short strobe left pins alone", 64'(pull_up_en), 64'(0));

    // R9 unmapped read, ignored write, single-cycle answer
    wr(8'hA0, 32'hDEAD_BEEF);
    rd(8'hA0, rv, v);
    check("R9 unmapped read", 64'(rv), 64'(0));
    check("R9 rd_valid after read", 64'(v), 64'(1));
    idle(1);
    check("R9 rd_valid one cycle", 64'(rd_valid), 64'(0));
    wr(8'h90, 32'h3);
    rd(8'h94, rv, v);
    check("R9 stray write kept ctrl", 64'(rv), 64'(2));

    // vector table
    for (int i = 0; i < 8; i++) begin
      wr(8'h94, 32'(VECS[i].code));
      wr(8'h98, VECS[i].lo);
      wr(8'h9C, VECS[i].hi);
      idle(int'(VECS[i].gap));
      wr(8'h98, 32'h0);
      wr(8'h9C, 32'h0);
      idle(2);
      if (VECS[i].gap >= HOLD && VECS[i].code != 2'd3) begin
        for (int p = 0; p < NP; p++) begin
          if (p < 32 ? VECS[i].lo[p] : VECS[i].hi[p-32]) begin
            exp_up[p] = VECS[i].code == 2'd2;
            exp_dn[p] = VECS[i].code == 2'd1;
          end
        end
      end
      check($sformatf("R%0d vector %0d up", VECS[i].tag, i), 64'(pull_up_en), 64'(exp_up));
      check($sformatf("R%0d vector %0d down", VECS[i].tag, i), 64'(pull_dn_en), 64'(exp_dn));
    end

    // R8 rewriting the code restarts the hold window
    wr(8'h94, 32'h1);
    wr(8'h98, 32'h0010_0000);
    idle(100);
    wr(8'h94, 32'h1);
    idle(100);
    wr(8'h98, 32'h0);
    idle(2);
    check("R8 restart blocks pin 20", 64'(pull_dn_en), 64'(exp_dn));

    done = 1;
    summary();
  end

endmodule